// File: doc/BRIEF.md
# Bidirectional Parallel/Serial Bus Register

An eight-stage storage register that sits between two 8-bit parallel buses, A and B, and also has a single-bit serial input. One register serves all uses. It can copy a word from either bus to the other, shift a serial stream in and show the assembled word on either bus, hold its word by recirculation, or take a word from a bus and shift it out through its top stage.

Four mode inputs select the operation, giving a twelve-row mode table. `dir_a2b` picks the direction of transfer. `a_side_en` gates the A side. `par_sel` chooses between parallel transfer and serial shifting. `async_sel` makes a parallel load transparent instead of clocked. Each bus is modelled as a separate input vector, output vector and output enable. The enables are combinational decodes of the direction and A-side controls, and they are forced low during reset.

A parallel load with `async_sel` high is modelled as a bypass. The selected output shows the source bus in the same cycle, and the register also captures that bus on every rising edge, so the word is still held after `async_sel` falls.

Top module: `bus_xfer_reg`

## Requirements
- R1: While `rst_n` is low, all stages read as 0, `a_oe` and `b_oe` are 0 and `ser_out` is 0, whatever the mode inputs are.
- R2: `b_oe` equals `dir_a2b`, and `a_oe` equals (not `dir_a2b`) and `a_side_en`, each in the same cycle. The two enables are never high together.
- R3: With `par_sel`=1, `async_sel`=0, `dir_a2b`=1 and `a_side_en`=1, the word on `a_in` is stored at the rising edge and appears on `b_out` after that edge, not before it.
- R4: With `par_sel`=1, `async_sel`=0 and `dir_a2b`=0, the word on `b_in` is stored at the rising edge whatever the value of `a_side_en`, and appears on `a_out` after that edge.
- R5: With `par_sel`=1, `async_sel`=1 and a load selected (`dir_a2b`=0, or `dir_a2b`=1 with `a_side_en`=1), the output bus follows the source bus in the same cycle with no clock edge, including changes within one cycle. The value is also stored at each rising edge.
- R6: With `par_sel`=1, `dir_a2b`=1 and `a_side_en`=0, the stored word is kept across rising edges whatever `a_in` and `async_sel` are, and `b_out` keeps showing it.
- R7: With `par_sel`=0, each rising edge shifts the word one place toward bit 7 and puts `ser_in` into bit 0. `async_sel` has no effect, and nothing changes before the edge.
- R8: `ser_out` is bit 7 of the stored word. A word loaded in parallel is therefore shifted out most significant bit first, one bit per edge, and the register is empty after eight shifts with `ser_in`=0.
- R9: In serial mode the shifted word is presented on `b_out` with `b_oe`=1 when `dir_a2b`=1. It is presented on `a_out` with `a_oe`=1 when `dir_a2b`=0 and `a_side_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_a2b | input | 1 | 1: A is the source and B is driven; 0: B is the source and A is driven |
| a_side_en | input | 1 | Enables the A side, as input or as driver |
| par_sel | input | 1 | 1: parallel transfer; 0: serial shift |
| async_sel | input | 1 | 1: transparent parallel load; ignored in serial mode |
| ser_in | input | 1 | Serial data into bit 0 |
| a_in | input | WIDTH | A bus input lines |
| a_out | output | WIDTH | A bus driven value |
| a_oe | output | 1 | A bus output enable |
| b_in | input | WIDTH | B bus input lines |
| b_out | output | WIDTH | B bus driven value |
| b_oe | output | 1 | B bus output enable |
| ser_out | output | 1 | Top stage, for shifting a word out |

## Verification
Clocked loads, shifts and holds take effect one rising edge after the inputs are applied. The bench drives every input on a falling edge and reads the registered result at the next falling edge. Output enables and transparent loads are due in the same cycle, so they are read one nanosecond after the drive, before any edge. That same early read also confirms that clocked modes have not yet changed the output. During shift-out, `ser_out` is read once per cycle before each edge, and it must show the next lower bit of the loaded word in each successive cycle.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD_A = 2'd1,
        OP_LOAD_B = 2'd2,
        OP_SHIFT  = 2'd3
    } bxr_op_e;

    typedef struct packed {
        bxr_op_e op;
        logic    transp;
        logic    a_oe;
        logic    b_oe;
    } bxr_ctl_t;

endpackage

// File: rtl/bxr_ctrl.sv
module bxr_ctrl
    import bxr_pkg::*;
(
    input  logic     rst_n,
    input  logic     dir_a2b,
    input  logic     a_side_en,
    input  logic     par_sel,
    input  logic     async_sel,
    output bxr_ctl_t ctl_o
);

    always_comb begin
        ctl_o = '0;
        if (!par_sel) begin
            ctl_o.op = OP_SHIFT;
        end else if (dir_a2b) begin
            ctl_o.op = a_side_en ? OP_LOAD_A : OP_HOLD;
        end else begin
            ctl_o.op = OP_LOAD_B;
        end
        ctl_o.transp = rst_n && par_sel && async_sel && (ctl_o.op != OP_HOLD);
        ctl_o.a_oe   = rst_n && !dir_a2b && a_side_en;
        ctl_o.b_oe   = rst_n && dir_a2b;
    end

endmodule

// File: rtl/bxr_stages.sv
module bxr_stages
    import bxr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bxr_ctl_t         ctl_i,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] word_o,
    output logic             top_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } st_t;

    st_t              st_d, st_q;
    logic [WIDTH-1:0] src;

    always_comb begin
        src  = (ctl_i.op == OP_LOAD_A) ? a_in : b_in;
        st_d = st_q;
        unique case (ctl_i.op)
            OP_LOAD_A: st_d.data = a_in;
            OP_LOAD_B: st_d.data = b_in;
            OP_SHIFT:  st_d.data = {st_q.data[MSB-1:0], ser_in};
            default:   st_d.data = st_q.data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = ctl_i.transp ? src : st_q.data;
    assign top_o  = st_q.data[MSB];

    assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.op == OP_SHIFT) |=> (st_q.data == {$past(st_q.data[MSB-1:0]), $past(ser_in)}));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.op == OP_HOLD) |=> $stable(st_q.data));

    assert_load_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.op == OP_LOAD_A) |=> (st_q.data == $past(a_in)));

    assert_load_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.op == OP_LOAD_B) |=> (st_q.data == $past(b_in)));

endmodule

// File: rtl/bus_xfer_reg.sv
module bus_xfer_reg
    import bxr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_a2b,
    input  logic             a_side_en,
    input  logic             par_sel,
    input  logic             async_sel,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             ser_out
);

    bxr_ctl_t         ctl;
    logic [WIDTH-1:0] word;

    bxr_ctrl u_ctrl (
        .rst_n     (rst_n),
        .dir_a2b   (dir_a2b),
        .a_side_en (a_side_en),
        .par_sel   (par_sel),
        .async_sel (async_sel),
        .ctl_o     (ctl)
    );

    bxr_stages #(.WIDTH(WIDTH)) u_stages (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl),
        .a_in   (a_in),
        .b_in   (b_in),
        .ser_in (ser_in),
        .word_o (word),
        .top_o  (ser_out)
    );

    assign a_out = word;
    assign b_out = word;
    assign a_oe  = ctl.a_oe;
    assign b_oe  = ctl.b_oe;

    assert_oe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

    assert_transp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && async_sel && dir_a2b && a_side_en) |-> (b_out == a_in));

    assert_transp_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && async_sel && !dir_a2b) |-> (a_out == b_in));

    assert_serout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_sel && async_sel) |-> (ser_out == b_out[WIDTH-1]));

    always_comb begin
        if (!rst_n) begin
            assert_reset_R1: assert (!a_oe && !b_oe);
        end
    end

endmodule

// File: tb/bus_xfer_reg_bench.sv
module bus_xfer_reg_bench;

    localparam int W = 8;
    localparam int NVEC = 12;
    localparam int TIMEOUT_NS = 100000;

    typedef struct packed {
        logic [3:0]   ctl;   // {a_side_en, par_sel, dir_a2b, async_sel}
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         s;
        logic [W-1:0] pre;   // output word before the edge
        logic [W-1:0] post;  // output word after the edge
        logic         aoe;
        logic         boe;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{4'b0000, 8'hFF, 8'h00, 1'b1, 8'h00, 8'h01, 1'b0, 1'b0},
        '{4'b0011, 8'hFF, 8'hFF, 1'b0, 8'h01, 8'h02, 1'b0, 1'b1},
        '{4'b0100, 8'hFF, 8'h5A, 1'b0, 8'h02, 8'h5A, 1'b0, 1'b0},
        '{4'b0101, 8'h00, 8'h3C, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0},
        '{4'b0110, 8'hAA, 8'h00, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b1},
        '{4'b0111, 8'h55, 8'h00, 1'b1, 8'h3C, 8'h3C, 1'b0, 1'b1},
        '{4'b1000, 8'h00, 8'hFF, 1'b1, 8'h3C, 8'h79, 1'b1, 1'b0},
        '{4'b1010, 8'h00, 8'h00, 1'b0, 8'h79, 8'hF2, 1'b0, 1'b1},
        '{4'b1100, 8'h00, 8'hC3, 1'b1, 8'hF2, 8'hC3, 1'b1, 1'b0},
        '{4'b1101, 8'h00, 8'h96, 1'b0, 8'h96, 8'h96, 1'b1, 1'b0},
        '{4'b1110, 8'h81, 8'h00, 1'b0, 8'h96, 8'h81, 1'b0, 1'b1},
        '{4'b1111, 8'h7E, 8'h00, 1'b0, 8'h7E, 8'h7E, 1'b0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_a2b = 1'b0, a_side_en = 1'b0, par_sel = 1'b0, async_sel = 1'b0, ser_in = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, ser_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_xfer_reg #(.WIDTH(W)) u_bus_xfer_reg (
        .clk(clk), .rst_n(rst_n), .dir_a2b(dir_a2b), .a_side_en(a_side_en),
        .par_sel(par_sel), .async_sel(async_sel), .ser_in(ser_in),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [3:0] c);
        if (!c[2])               return "R7";
        if (c[1] && !c[3])       return "R6";
        if (c[0])                return "R5";
        if (c[1])                return "R3";
        return "R4";
    endfunction

    function automatic logic [W-1:0] shown();
        return dir_a2b ? b_out : a_out;
    endfunction

    initial begin
        #(TIMEOUT_NS);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with direction toward B
        dir_a2b = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "word at reset", b_out, 8'h00);
        check("R1", "a_oe at reset", {7'd0, a_oe}, 8'h00);
        check("R1", "b_oe at reset", {7'd0, b_oe}, 8'h00);
        check("R1", "ser_out at reset", {7'd0, ser_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Twelve-mode table
        for (int i = 0; i < NVEC; i++) begin
            {a_side_en, par_sel, dir_a2b, async_sel} = VEC[i].ctl;
            a_in = VEC[i].a;
            b_in = VEC[i].b;
            ser_in = VEC[i].s;
            #1;
            check(mode_tag(VEC[i].ctl), $sformatf("row %0d before edge", i), shown(), VEC[i].pre);
            check(VEC[i].ctl[2] ? "R2" : "R9", $sformatf("row %0d a_oe", i), {7'd0, a_oe}, {7'd0, VEC[i].aoe});
            check(VEC[i].ctl[2] ? "R2" : "R9", $sformatf("row %0d b_oe", i), {7'd0, b_oe}, {7'd0, VEC[i].boe});
            @(posedge clk);
            @(negedge clk);
            check(mode_tag(VEC[i].ctl), $sformatf("row %0d after edge", i), shown(), VEC[i].post);
            check("R8", $sformatf("row %0d ser_out", i), {7'd0, ser_out}, {7'd0, VEC[i].post[W-1]});
        end

        // R5: transparent load follows changes inside one cycle
        {a_side_en, par_sel, dir_a2b, async_sel} = 4'b0101;
        b_in = 8'h11;
        #1;
        check("R5", "follow first value", a_out, 8'h11);
        b_in = 8'hEE;
        #1;
        check("R5", "follow second value", a_out, 8'hEE);

        // R8: load 0xB4 from A, then shift it out MSB first
        @(negedge clk);
        {a_side_en, par_sel, dir_a2b, async_sel} = 4'b1110;
        a_in = 8'hB4;
        @(posedge clk);
        @(negedge clk);
        par_sel = 1'b0;
        ser_in = 1'b0;
        async_sel = 1'b1; // ignored in serial mode (R7)
        for (int k = 0; k < W; k++) begin
            #1;
            check("R8", $sformatf("shift-out bit %0d", k), {7'd0, ser_out}, {7'd0, 8'hB4 >> (W - 1 - k)} & 8'h01);
            @(posedge clk);
            @(negedge clk);
        end
        #1;
        check("R8", "empty after eight shifts", b_out, 8'h00);
        check("R9", "serial word on B enable", {7'd0, b_oe}, 8'h01);

        // R1: reset in the middle of operation, async parallel mode selected
        {a_side_en, par_sel, dir_a2b, async_sel} = 4'b1110;
        a_in = 8'hA5;
        @(posedge clk);
        @(negedge clk);
        check("R1", "word before reset", b_out, 8'hA5);
        async_sel = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R1", "word in reset", b_out, 8'h00);
        check("R1", "b_oe in reset", {7'd0, b_oe}, 8'h00);
        check("R1", "ser_out in reset", {7'd0, ser_out}, 8'h00);
        dir_a2b = 1'b0;
        #1;
        check("R1", "a_oe in reset", {7'd0, a_oe}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule